// File: doc/BRIEF.md
# Keyword-Gated Host Command Sequencer with Watchdog

This block is the host-side control unit of a multi-channel power load driver. A host processor writes 8-bit words over a narrow parallel bus: four address bits and four data bits, framed by an active-low chip select and an active-low write strobe. The strobes are asynchronous to the block clock. They pass through a two-flop synchroniser, and each write pulse yields exactly one captured word, assembled as `{A3,A2,A1,A0,D3,D2,D1,D0}`.

After power-good rises, the block holds its reset output low for a delay. It then ignores every word until the unlock keyword arrives. The keyword enables the power stages and starts a watchdog, which the host must keep feeding with refresh words. The two bridge channels must each be configured exactly once before they accept commands. The solenoid channel needs no configuration. Accepted commands leave the block as one-cycle strobes that carry the channel index and the 4-bit data field, and the DAC and chopper blocks consume them.

If the watchdog expires, the power stages latch off until power-good drops and the keyword sequence is repeated. The reset output stays high in that case. If a channel is configured twice, the power stages turn off and the reset output pulses low for the delay period. The block then waits for a fresh keyword.

Top module: `drv_cmd_sequencer`

## Requirements
- R1: While `pwrGood` is low, `rstOutN` and `powerEn` are 0. After `pwrGood` rises, `rstOutN` goes high after exactly `RST_DELAY` clock edges. `powerEn` is never 1 while `rstOutN` is 0.
- R2: A word is captured only while both `csN` and `wrN` are low. Exactly one word is captured per write pulse, however long the pulse lasts. A write with `csN` high captures nothing.
- R3: Before the unlock keyword `{A3..A0,D3..D0}` = 0011_1010, every word is ignored: no strobe is emitted and `powerEn` stays 0.
- R4: The keyword sets `powerEn`, restarts the watchdog and clears the configured state of both bridge channels. A keyword received while running clears that state again.
- R5: The refresh word 0011_1010's sibling 0011_0101 restarts the watchdog. If `WD_CYCLES` edges pass after the last accepted keyword or refresh, `powerEn` falls and `rstOutN` stays high. The outputs then stay off, and keywords are ignored, until `pwrGood` drops.
- R6: A refresh accepted at the very edge where the watchdog would expire wins, and `powerEn` stays 1. A refresh accepted one edge later is ignored.
- R7: The channel is taken from {A2,A3}: 10 gives channel 1, 01 gives channel 2, 11 gives channel 3, and 00 is reserved. Any non-special word on 00 is ignored. The operation is taken from {A0,A1}: 00 configures, 01 loads a DAC (`dacLoad`), 10 sets the drive strategy (`strategyWe`) and 11 steps a DAC (`dacIncDec`). `cmdChan` carries the channel as 1, 2 or 3.
- R8: A configure word raises `cfgWe` only for channel 1 or 2 and only with a legal data code. A code is legal when D1:D0 is not 11 and D3:D2 is not 11. Any other configure word is ignored.
- R9: A second legal configure word for an already configured channel drops `powerEn` and drives `rstOutN` low for `RST_DELAY` cycles. Afterwards the block is locked again and needs the keyword.
- R10: DAC and strategy commands for channel 1 or 2 are discarded until that channel is configured. Commands for channel 3 are always accepted while running.
- R11: Each accepted command produces one strobe for exactly one cycle, and never more than one strobe at once. `cmdChan` and `cmdData` carry the command's channel and D3..D0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwrGood | input | 1 | Supplies-good indication, synchronous to clk |
| csN | input | 1 | Bus chip select, active low, asynchronous |
| wrN | input | 1 | Bus write strobe, active low, asynchronous |
| busAddr | input | 4 | A3..A0 of the bus word |
| busData | input | 4 | D3..D0 of the bus word |
| rstOutN | output | 1 | Reset output to the host, active low |
| powerEn | output | 1 | Enable for all power stages |
| cfgWe | output | 1 | Channel configuration strobe |
| dacLoad | output | 1 | DAC load strobe |
| dacIncDec | output | 1 | DAC increment/decrement strobe |
| strategyWe | output | 1 | Drive-strategy write strobe |
| cmdChan | output | 2 | Channel of the last strobe (1, 2, 3) |
| cmdData | output | 4 | D3..D0 of the last strobe |

## Verification
The hardest collision is a refresh word landing in the same clock cycle in which the watchdog count reaches its limit. The intended result is that the refresh wins. The bench provokes this by timing the refresh write, counted in clock edges from the keyword write, so that the word is accepted exactly at the expiry edge. It repeats the test one edge later. The result is judged only at the ports: `powerEn` must stay high in the first case and must be low with `rstOutN` still high in the second.

// File: rtl/drv_seq_pkg.sv
package drv_seq_pkg;

  typedef enum logic [2:0] {
    ST_RESET,
    ST_LOCKED,
    ST_ACTIVE,
    ST_WDTRIP,
    ST_DUPHOLD
  } seqState_t;

  typedef struct packed {
    logic       cfg;
    logic       load;
    logic       incDec;
    logic       strat;
    logic [1:0] chan;
    logic [3:0] data;
  } cmdStrobe_t;

  localparam logic [7:0] UNLOCK_WORD  = 8'h3A;
  localparam logic [7:0] REFRESH_WORD = 8'h35;

  function automatic logic isLegalCfg(input logic [3:0] code);
    return (code[1:0] != 2'b11) && (code[3:2] != 2'b11);
  endfunction

endpackage

// File: rtl/drv_bus_capture.sv
module drv_bus_capture #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       wrN,
  input  logic [3:0] busAddr,
  input  logic [3:0] busData,
  output logic       wordValid,
  output logic [7:0] word
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] csSync;
  logic [TOP:0] wrSync;
  logic         writeActive;
  logic         writeActiveQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csSync       <= '1;
      wrSync       <= '1;
      writeActiveQ <= 1'b0;
    end else begin
      csSync       <= {csSync[TOP-1:0], csN};
      wrSync       <= {wrSync[TOP-1:0], wrN};
      writeActiveQ <= writeActive;
    end
  end

  assign writeActive = !csSync[TOP] && !wrSync[TOP];
  assign wordValid   = writeActive && !writeActiveQ;
  assign word        = {busAddr, busData};
endmodule

// File: rtl/drv_seq_ctrl.sv
module drv_seq_ctrl
  import drv_seq_pkg::*;
#(
  parameter int WD_CYCLES = 50000,
  parameter int RST_DELAY = 20000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwrGood,
  input  logic       wordValid,
  input  logic [7:0] word,
  output cmdStrobe_t strobe,
  output logic       powerEn,
  output logic       rstOutN
);
  localparam int MAX_COUNT = (WD_CYCLES > RST_DELAY) ? WD_CYCLES : RST_DELAY;
  localparam int TMR_W     = $clog2(MAX_COUNT + 1);

  seqState_t        state, nextState;
  logic [TMR_W-1:0] tmr, nextTmr;
  logic [1:0]       cfgd, nextCfgd;

  logic [1:0] chan;
  logic       opCfg, opLoad, opStrat, opStep;
  logic       isUnlock, isRefresh, chanCfgd, wdExpired, delayDone;

  assign chan      = (word[6] && word[7]) ? 2'd3 : word[6] ? 2'd1 : word[7] ? 2'd2 : 2'd0;
  assign opCfg     = !word[4] && !word[5];
  assign opLoad    = !word[4] &&  word[5];
  assign opStrat   =  word[4] && !word[5];
  assign opStep    =  word[4] &&  word[5];
  assign isUnlock  = wordValid && (word == UNLOCK_WORD);
  assign isRefresh = wordValid && (word == REFRESH_WORD);
  assign chanCfgd  = (chan == 2'd1) ? cfgd[0] : cfgd[1];
  assign wdExpired = (tmr == TMR_W'(WD_CYCLES - 1));
  assign delayDone = (tmr == TMR_W'(RST_DELAY - 1));

  always_comb begin
    nextState   = state;
    nextTmr     = tmr;
    nextCfgd    = cfgd;
    strobe      = '0;
    strobe.chan = chan;
    strobe.data = word[3:0];
    if (!pwrGood) begin
      nextState = ST_RESET;
      nextTmr   = '0;
      nextCfgd  = '0;
    end else begin
      case (state)
        ST_RESET, ST_DUPHOLD: begin
          if (delayDone) begin
            nextState = ST_LOCKED;
            nextTmr   = '0;
          end else begin
            nextTmr = tmr + 1'b1;
          end
        end
        ST_LOCKED: begin
          if (isUnlock) begin
            nextState = ST_ACTIVE;
            nextTmr   = '0;
            nextCfgd  = '0;
          end
        end
        ST_ACTIVE: begin
          if (isUnlock || isRefresh) begin
            nextTmr = '0;
            if (isUnlock) nextCfgd = '0;
          end else if (wdExpired) begin
            nextState = ST_WDTRIP;
          end else begin
            nextTmr = tmr + 1'b1;
            if (wordValid && chan != 2'd0) begin
              if (opCfg) begin
                if (chan != 2'd3 && isLegalCfg(word[3:0])) begin
                  if (chanCfgd) begin
                    nextState = ST_DUPHOLD;
                    nextTmr   = '0;
                    nextCfgd  = '0;
                  end else begin
                    if (chan == 2'd1) nextCfgd[0] = 1'b1;
                    else              nextCfgd[1] = 1'b1;
                    strobe.cfg = 1'b1;
                  end
                end
              end else if (chan == 2'd3 || chanCfgd) begin
                strobe.load   = opLoad;
                strobe.strat  = opStrat;
                strobe.incDec = opStep;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_RESET;
      tmr   <= '0;
      cfgd  <= '0;
    end else begin
      state <= nextState;
      tmr   <= nextTmr;
      cfgd  <= nextCfgd;
    end
  end

  assign powerEn = (state == ST_ACTIVE);
  assign rstOutN = !((state == ST_RESET) || (state == ST_DUPHOLD));
endmodule

// File: rtl/drv_cmd_outreg.sv
module drv_cmd_outreg
  import drv_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  cmdStrobe_t strobe,
  output logic       cfgWe,
  output logic       dacLoad,
  output logic       dacIncDec,
  output logic       strategyWe,
  output logic [1:0] cmdChan,
  output logic [3:0] cmdData
);
  logic anyFire;
  assign anyFire = strobe.cfg || strobe.load || strobe.incDec || strobe.strat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgWe      <= 1'b0;
      dacLoad    <= 1'b0;
      dacIncDec  <= 1'b0;
      strategyWe <= 1'b0;
      cmdChan    <= '0;
      cmdData    <= '0;
    end else begin
      cfgWe      <= strobe.cfg;
      dacLoad    <= strobe.load;
      dacIncDec  <= strobe.incDec;
      strategyWe <= strobe.strat;
      if (anyFire) begin
        cmdChan <= strobe.chan;
        cmdData <= strobe.data;
      end
    end
  end
endmodule

// File: rtl/drv_cmd_sequencer.sv
module drv_cmd_sequencer
  import drv_seq_pkg::*;
#(
  parameter int WD_CYCLES   = 50000,
  parameter int RST_DELAY   = 20000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwrGood,
  input  logic       csN,
  input  logic       wrN,
  input  logic [3:0] busAddr,
  input  logic [3:0] busData,
  output logic       rstOutN,
  output logic       powerEn,
  output logic       cfgWe,
  output logic       dacLoad,
  output logic       dacIncDec,
  output logic       strategyWe,
  output logic [1:0] cmdChan,
  output logic [3:0] cmdData
);
  logic       wordValid;
  logic [7:0] word;
  cmdStrobe_t strobe;

  drv_bus_capture #(.SYNC_STAGES(SYNC_STAGES)) i_capture (
    .clk(clk), .rstN(rstN), .csN(csN), .wrN(wrN),
    .busAddr(busAddr), .busData(busData),
    .wordValid(wordValid), .word(word)
  );

  drv_seq_ctrl #(.WD_CYCLES(WD_CYCLES), .RST_DELAY(RST_DELAY)) i_ctrl (
    .clk(clk), .rstN(rstN), .pwrGood(pwrGood),
    .wordValid(wordValid), .word(word),
    .strobe(strobe), .powerEn(powerEn), .rstOutN(rstOutN)
  );

  drv_cmd_outreg i_outreg (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cfgWe(cfgWe), .dacLoad(dacLoad), .dacIncDec(dacIncDec),
    .strategyWe(strategyWe), .cmdChan(cmdChan), .cmdData(cmdData)
  );
endmodule

// File: rtl/drv_cmd_sequencer_chk.sv
module drv_cmd_sequencer_chk (
  input logic       clk,
  input logic       rstN,
  input logic       pwrGood,
  input logic       rstOutN,
  input logic       powerEn,
  input logic       cfgWe,
  input logic       dacLoad,
  input logic       dacIncDec,
  input logic       strategyWe,
  input logic [1:0] cmdChan,
  input logic [3:0] cmdData
);
  logic anyStrobe;
  assign anyStrobe = cfgWe || dacLoad || dacIncDec || strategyWe;

  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cfgWe, dacLoad, dacIncDec, strategyWe}));  // R11

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    anyStrobe |=> !anyStrobe);  // R11

  AST_STROBE_NEEDS_POWER: assert property (@(posedge clk) disable iff (!rstN)
    anyStrobe |-> $past(powerEn));  // R3

  AST_STROBE_CHAN_VALID: assert property (@(posedge clk) disable iff (!rstN)
    anyStrobe |-> (cmdChan != 2'd0));  // R7

  AST_CFG_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |-> (cmdChan != 2'd3 && cmdData[1:0] != 2'b11 && cmdData[3:2] != 2'b11));  // R8

  AST_RSTOUT_BLOCKS_POWER: assert property (@(posedge clk) disable iff (!rstN)
    !rstOutN |-> !powerEn);  // R1

  AST_NO_GOOD_NO_POWER: assert property (@(posedge clk) disable iff (!rstN)
    !pwrGood |=> (!powerEn && !rstOutN));  // R1

  AST_WD_TRIP_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(powerEn) && rstOutN) |=> !powerEn);  // R5
endmodule

bind drv_cmd_sequencer drv_cmd_sequencer_chk i_chk (.*);

// File: tb/test_drv_cmd_sequencer.sv
module test_drv_cmd_sequencer;
  localparam int WD   = 200;
  localparam int RSTD = 12;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rstN, pwrGood, csN, wrN;
  logic [3:0] busAddr, busData;
  logic       rstOutN, powerEn, cfgWe, dacLoad, dacIncDec, strategyWe;
  logic [1:0] cmdChan;
  logic [3:0] cmdData;

  drv_cmd_sequencer #(.WD_CYCLES(WD), .RST_DELAY(RSTD), .SYNC_STAGES(2)) i_drv_cmd_sequencer (
    .clk(clk), .rstN(rstN), .pwrGood(pwrGood), .csN(csN), .wrN(wrN),
    .busAddr(busAddr), .busData(busData), .rstOutN(rstOutN), .powerEn(powerEn),
    .cfgWe(cfgWe), .dacLoad(dacLoad), .dacIncDec(dacIncDec), .strategyWe(strategyWe),
    .cmdChan(cmdChan), .cmdData(cmdData)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int nCfg = 0, nLoad = 0, nStep = 0, nStrat = 0;
  int sCfg, sLoad, sStep, sStrat;
  logic [1:0] lastChan = '0;
  logic [3:0] lastData = '0;

  always @(negedge clk) begin
    if (cfgWe)      nCfg++;
    if (dacLoad)    nLoad++;
    if (dacIncDec)  nStep++;
    if (strategyWe) nStrat++;
    if (cfgWe || dacLoad || dacIncDec || strategyWe) begin
      lastChan = cmdChan;
      lastData = cmdData;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic snap();
    sCfg = nCfg; sLoad = nLoad; sStep = nStep; sStrat = nStrat;
  endtask

  task automatic expectStrobes(input string tag, input int c, input int l, input int s, input int t);
    chk({tag, " cfgWe count"},      nCfg - sCfg,     c);
    chk({tag, " dacLoad count"},    nLoad - sLoad,   l);
    chk({tag, " dacIncDec count"},  nStep - sStep,   s);
    chk({tag, " strategyWe count"}, nStrat - sStrat, t);
  endtask

  task automatic writeWord(input logic [3:0] a, input logic [3:0] d, input bit useCs = 1'b1,
                           input int hold = 4);
    @(negedge clk);
    busAddr = a; busData = d; csN = !useCs; wrN = 1'b0;
    repeat (hold) @(negedge clk);
    wrN = 1'b1; csN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic powerUp();
    int k;
    chk("R1 rstOutN low before power-good", int'(rstOutN), 0);
    chk("R1 powerEn low before power-good", int'(powerEn), 0);
    @(negedge clk);
    pwrGood = 1'b1;
    k = 0;
    while (!rstOutN && k < 200) begin
      @(negedge clk);
      k++;
    end
    chk("R1 reset delay edges", k, RSTD);
    chk("R1 powerEn still off after release", int'(powerEn), 0);
  endtask

  task automatic powerCycle();
    @(negedge clk);
    pwrGood = 1'b0;
    repeat (3) @(negedge clk);
    powerUp();
  endtask

  task automatic tLocked();
    snap();
    writeWord(4'hE, 4'h6);
    writeWord(4'h3, 4'h5);
    writeWord(4'h4, 4'h1);
    expectStrobes("R3 words before keyword", 0, 0, 0, 0);
    chk("R3 powerEn before keyword", int'(powerEn), 0);
  endtask

  task automatic tKeyword();
    writeWord(4'h3, 4'hA);
    chk("R4 keyword enables power", int'(powerEn), 1);
    chk("R4 rstOutN high", int'(rstOutN), 1);
  endtask

  task automatic tConfig();
    snap();
    writeWord(4'h8, 4'hC);
    writeWord(4'hC, 4'h1);
    expectStrobes("R8 illegal or channel-3 configure", 0, 0, 0, 0);
    snap();
    writeWord(4'h4, 4'h5);
    expectStrobes("R8 legal configure ch1", 1, 0, 0, 0);
    chk("R11 cfg channel", int'(lastChan), 1);
    chk("R11 cfg data", int'(lastData), 5);
  endtask

  task automatic tCommands();
    writeWord(4'h3, 4'h5);
    snap();
    writeWord(4'h6, 4'hB);
    expectStrobes("R7 load ch1", 0, 1, 0, 0);
    chk("R7 load ch1 channel", int'(lastChan), 1);
    chk("R7 load ch1 data", int'(lastData), 11);
    snap();
    writeWord(4'h5, 4'h3);
    expectStrobes("R7 strategy ch1", 0, 0, 0, 1);
    snap();
    writeWord(4'h7, 4'h1);
    expectStrobes("R7 step ch1", 0, 0, 1, 0);
    snap();
    writeWord(4'hE, 4'h6);
    expectStrobes("R10 load ch3 without configure", 0, 1, 0, 0);
    chk("R10 ch3 channel", int'(lastChan), 3);
    chk("R10 ch3 data", int'(lastData), 6);
    snap();
    writeWord(4'hA, 4'h2);
    expectStrobes("R10 load unconfigured ch2", 0, 0, 0, 0);
    snap();
    writeWord(4'h1, 4'h0);
    expectStrobes("R7 reserved channel word", 0, 0, 0, 0);
    snap();
    writeWord(4'h6, 4'h2, 1'b0);
    expectStrobes("R2 write with chip select high", 0, 0, 0, 0);
    snap();
    writeWord(4'h6, 4'h4, 1'b1, 12);
    expectStrobes("R2 long write pulse", 0, 1, 0, 0);
    chk("R11 long write data", int'(lastData), 4);
    chk("R5 still running", int'(powerEn), 1);
  endtask

  task automatic tKeyClears();
    writeWord(4'h3, 4'hA);
    snap();
    writeWord(4'h6, 4'h1);
    expectStrobes("R4 keyword cleared ch1 config", 0, 0, 0, 0);
    snap();
    writeWord(4'h4, 4'h2);
    expectStrobes("R4 reconfigure after keyword", 1, 0, 0, 0);
    chk("R4 power after reconfigure", int'(powerEn), 1);
  endtask

  task automatic tDuplicate();
    int k, lowCnt;
    snap();
    @(negedge clk);
    busAddr = 4'h4; busData = 4'h9; csN = 1'b0; wrN = 1'b0;
    k = 0;
    while (rstOutN && k < 20) begin
      @(negedge clk);
      k++;
    end
    lowCnt = 0;
    while (!rstOutN && lowCnt < 200) begin
      chk("R9 power off during duplicate hold", int'(powerEn), 0);
      lowCnt++;
      @(negedge clk);
    end
    wrN = 1'b1; csN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 duplicate reset pulse length", lowCnt, RSTD);
    expectStrobes("R9 duplicate emits no cfgWe", 0, 0, 0, 0);
    chk("R9 locked after duplicate", int'(powerEn), 0);
    snap();
    writeWord(4'hE, 4'h3);
    expectStrobes("R9 commands ignored while locked", 0, 0, 0, 0);
    writeWord(4'h3, 4'hA);
    chk("R9 keyword restarts", int'(powerEn), 1);
    snap();
    writeWord(4'h4, 4'h9);
    expectStrobes("R9 configure after restart", 1, 0, 0, 0);
  endtask

  task automatic tWatchdog();
    writeWord(4'h3, 4'hA);
    for (int i = 0; i < 5; i++) begin
      repeat (93) @(negedge clk);
      writeWord(4'h3, 4'h5);
    end
    chk("R5 refreshes keep power on", int'(powerEn), 1);
    repeat (WD + 20) @(negedge clk);
    chk("R5 watchdog trip drops power", int'(powerEn), 0);
    chk("R5 watchdog trip keeps rstOutN high", int'(rstOutN), 1);
    writeWord(4'h3, 4'hA);
    chk("R5 keyword ignored after trip", int'(powerEn), 0);
    powerCycle();
    writeWord(4'h3, 4'hA);
    chk("R5 power-on and keyword recover", int'(powerEn), 1);
  endtask

  task automatic tBoundary(input int m, input int expPower);
    @(negedge clk);
    busAddr = 4'h3; busData = 4'hA; csN = 1'b0; wrN = 1'b0;
    repeat (4) @(negedge clk);
    wrN = 1'b1; csN = 1'b1;
    repeat (m - 4) @(negedge clk);
    busAddr = 4'h3; busData = 4'h5; csN = 1'b0; wrN = 1'b0;
    repeat (4) @(negedge clk);
    wrN = 1'b1; csN = 1'b1;
    repeat (3) @(negedge clk);
    chk($sformatf("R6 refresh at offset %0d power", m), int'(powerEn), expPower);
    chk($sformatf("R6 refresh at offset %0d rstOutN", m), int'(rstOutN), 1);
  endtask

  initial begin
    rstN = 1'b0; pwrGood = 1'b0; csN = 1'b1; wrN = 1'b1;
    busAddr = '0; busData = '0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    snap();
    chk("R1 reset state rstOutN", int'(rstOutN), 0);
    chk("R1 reset state powerEn", int'(powerEn), 0);
    powerUp();
    tLocked();
    tKeyword();
    tConfig();
    tCommands();
    tKeyClears();
    tDuplicate();
    powerCycle();
    tWatchdog();
    powerCycle();
    tBoundary(WD, 1);
    powerCycle();
    tBoundary(WD + 1, 0);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule